// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits in front of a byte-wide flash bank's program/erase engine. It watches the stream of bus write cycles, each one a single-cycle strobe carrying a 19-bit address and a byte of data, and recognises the unlock-protected command sequences. Every sequence opens with the same two unlock writes, AAh to 5555h and then 55h to 2AAAh.

It recognises five sequences: byte program, 4 KB sector erase, whole-bank erase, identifier-mode entry and identifier-mode exit. When a program or erase sequence completes, the block raises a single-cycle start pulse to the engine. The pulse carries the captured address and data.

While the engine reports busy, every write is ignored. A write that breaks a sequence drops the decoder back to normal read mode. In identifier mode, a side read port returns the manufacturer and device codes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write with any address and data, raise `prog_start` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the fourth write. `op_addr` and `op_data` then hold that fourth write's full address and data.
- R2: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h at any address raise `sect_erase_start` one cycle after the sixth write. `op_addr` carries the sixth write's full address, whose bits 18..12 name the 4 KB sector, and `op_data` is 30h.
- R3: The same first five writes followed by 10h@5555h raise `bank_erase_start` one cycle after the sixth write, with `op_addr` set to that write's address and `op_data` set to 10h.
- R4: The writes AAh@5555h, 55h@2AAAh and 90h@5555h set `id_mode`. The flag is visible one cycle after the third write.
- R5: `id_mode` clears one cycle after either of two things: the writes AAh@5555h, 55h@2AAAh, F0h@5555h, or a lone F0h write at any address while no sequence is in progress.
- R6: While `id_mode` is 1, `id_data` is BFh when `rd_addr` is 0 and `DEVICE_CODE` (default 17h) when `rd_addr` is 1. In every other case `id_data` is 00h.
- R7: Command steps compare only address bits 14..0. Bits 18..15 of a command write have no effect on recognition.
- R8: A write that does not match the next expected step of any sequence returns the decoder to idle and clears `id_mode`. A write that matches the first step of a sequence leaves `id_mode` unchanged.
- R9: A write sampled while `engine_busy` is 1 is ignored. The sequence position, `id_mode` and all start outputs are left as they would be with no write.
- R10: Start pulses are mutually exclusive and last one cycle. After a launch the decoder is idle, so a new sequence can begin on the very next write.
- R11: After synchronous reset (`rst_n` low at a clock edge), all start pulses and `id_mode` are 0 and any partly entered sequence is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| engine_busy | input | 1 | Program/erase engine is running an operation |
| rd_addr | input | 19 | Read address for identifier reads |
| prog_start | output | 1 | Byte program launch pulse |
| sect_erase_start | output | 1 | Sector erase launch pulse |
| bank_erase_start | output | 1 | Bank erase launch pulse |
| op_addr | output | 19 | Address captured at launch |
| op_data | output | 8 | Data captured at launch |
| id_mode | output | 1 | Identifier mode active |
| id_data | output | 8 | Identifier code for `rd_addr` |

## Verification
The hardest situations to reach from the ports are those where a write arrives deep inside a six-step erase sequence while the engine is busy, and those where an aborting write lands while identifier mode is already on. Both need a long exact prefix to line up with a particular busy or mode condition. Directed sequences build each prefix on purpose: busy is raised just before the final step, and aborts are placed at every position of every sequence. After that, a long biased stream draws its addresses mostly from the two unlock locations, its data mostly from the command codes, and adds busy pulses. This stream reaches the crossings in combinations the directed cases do not list.

// File: rtl/flash_cmd_pkg.sv
// Package: flash_cmd_pkg
// Shared constants and types for the flash unlock command decoder.
// Assumes a byte-wide data bus and command addresses compared on 15 bits.
package flash_cmd_pkg;

    localparam int CMD_ADDR_W = 15;
    localparam int DATA_W     = 8;

    localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [CMD_ADDR_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [DATA_W-1:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [DATA_W-1:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [DATA_W-1:0] CODE_ERASE    = 8'h80;
    localparam logic [DATA_W-1:0] CODE_ID_ENTER = 8'h90;
    localparam logic [DATA_W-1:0] CODE_SECTOR   = 8'h30;
    localparam logic [DATA_W-1:0] CODE_BANK     = 8'h10;
    localparam logic [DATA_W-1:0] CODE_MFR_ID   = 8'hBF;

    // Position inside a command sequence
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_UNLK1  = 3'd1,
        SQ_UNLK2  = 3'd2,
        SQ_PROG   = 3'd3,
        SQ_ERASE3 = 3'd4,
        SQ_ERASE4 = 3'd5,
        SQ_ERASE5 = 3'd6
    } seq_state_t;

    // Operation launched by a completed sequence
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SECT  = 2'd2,
        OP_BANK  = 2'd3
    } launch_t;

    // Classification of a single bus write
    typedef struct packed {
        logic at_a;      // address low bits equal the first unlock location
        logic at_b;      // address low bits equal the second unlock location
        logic is_unl_a;
        logic is_unl_b;
        logic is_prog;
        logic is_erase;
        logic is_id_in;
        logic is_sector;
        logic is_bank;
    } wr_class_t;

endpackage

// File: rtl/flash_cmd_match.sv
// Module: flash_cmd_match
// Classifies one bus write against the command addresses and codes.
// Assumes only the low CMD_ADDR_W address bits take part in the comparison;
// the upper bits are never seen here.
module flash_cmd_match
    import flash_cmd_pkg::*;
(
    input  logic [CMD_ADDR_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]     data,
    output wr_class_t             cls
);

    // Compare address and data against every constant the sequences use
    always_comb begin
        cls.at_a      = (addr_lo == UNLOCK_ADDR_A);
        cls.at_b      = (addr_lo == UNLOCK_ADDR_B);
        cls.is_unl_a  = (data == CODE_UNLOCK_A);
        cls.is_unl_b  = (data == CODE_UNLOCK_B);
        cls.is_prog   = (data == CODE_PROGRAM);
        cls.is_erase  = (data == CODE_ERASE);
        cls.is_id_in  = (data == CODE_ID_ENTER);
        cls.is_sector = (data == CODE_SECTOR);
        cls.is_bank   = (data == CODE_BANK);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq
// Tracks the position in the unlock command sequences and launches
// program and erase operations with registered single-cycle pulses.
// Assumes a write strobe lasts one cycle; writes seen while busy are dropped.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              engine_busy,
    input  wr_class_t         cls,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              bank_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_set,
    output logic              id_clr
);

    seq_state_t state, state_nx;
    launch_t    launch;
    logic       take;

    assign take = wr_valid && !engine_busy;

    // Next sequence position, launch decision and identifier-mode events
    always_comb begin
        state_nx = state;
        launch   = OP_NONE;
        id_set   = 1'b0;
        id_clr   = 1'b0;
        if (take) begin
            state_nx = SQ_IDLE;
            unique case (state)
                SQ_IDLE: begin
                    if (cls.at_a && cls.is_unl_a) state_nx = SQ_UNLK1;
                    else                          id_clr   = 1'b1;
                end
                SQ_UNLK1: begin
                    if (cls.at_b && cls.is_unl_b) state_nx = SQ_UNLK2;
                    else                          id_clr   = 1'b1;
                end
                SQ_UNLK2: begin
                    if (cls.at_a && cls.is_prog)       state_nx = SQ_PROG;
                    else if (cls.at_a && cls.is_erase) state_nx = SQ_ERASE3;
                    else if (cls.at_a && cls.is_id_in) id_set   = 1'b1;
                    else                               id_clr   = 1'b1;
                end
                SQ_PROG: begin
                    launch = OP_PROG;
                end
                SQ_ERASE3: begin
                    if (cls.at_a && cls.is_unl_a) state_nx = SQ_ERASE4;
                    else                          id_clr   = 1'b1;
                end
                SQ_ERASE4: begin
                    if (cls.at_b && cls.is_unl_b) state_nx = SQ_ERASE5;
                    else                          id_clr   = 1'b1;
                end
                SQ_ERASE5: begin
                    if (cls.is_sector)               launch = OP_SECT;
                    else if (cls.at_a && cls.is_bank) launch = OP_BANK;
                    else                              id_clr = 1'b1;
                end
                default: begin
                    id_clr = 1'b1;
                end
            endcase
        end
    end

    // Sequence position register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // Registered launch pulses and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_start       <= 1'b0;
            sect_erase_start <= 1'b0;
            bank_erase_start <= 1'b0;
            op_addr          <= '0;
            op_data          <= '0;
        end else begin
            prog_start       <= (launch == OP_PROG);
            sect_erase_start <= (launch == OP_SECT);
            bank_erase_start <= (launch == OP_BANK);
            if (launch != OP_NONE) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, bank_erase_start})); // R10

    AST_IDLE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || sect_erase_start || bank_erase_start) |-> (state == SQ_IDLE)); // R10

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R10

    AST_BUSY_HOLDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> $stable(state)); // R9

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> !(prog_start || sect_erase_start || bank_erase_start)); // R9

endmodule

// File: rtl/flash_id_mode.sv
// Module: flash_id_mode
// Holds the identifier-mode flag and answers identifier reads.
// Assumes set and clear events never arrive in the same cycle.
module flash_id_mode
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W      = 19,
    parameter logic [DATA_W-1:0] DEVICE_CODE = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_set,
    input  logic              id_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_data
);

    // Identifier-mode flag register
    always_ff @(posedge clk) begin
        if (!rst_n)      id_mode <= 1'b0;
        else if (id_set) id_mode <= 1'b1;
        else if (id_clr) id_mode <= 1'b0;
    end

    // Identifier read multiplexer
    always_comb begin
        id_data = '0;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      id_data = CODE_MFR_ID;
            else if (rd_addr == ADDR_W'(1)) id_data = DEVICE_CODE;
        end
    end

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_set && id_clr)); // R8

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        id_set |=> id_mode); // R4

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder
// Top of the unlock command decoder: classifies each write, tracks the
// command sequence, launches program/erase and keeps identifier mode.
// Assumes ADDR_W is at least the 15 compared command address bits.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 19,
    parameter logic [7:0]  DEVICE_CODE = 8'h17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              engine_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              bank_erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode,
    output logic [7:0]        id_data
);

    wr_class_t cls;
    logic      id_set;
    logic      id_clr;

    flash_cmd_match u_match (
        .addr_lo (wr_addr[CMD_ADDR_W-1:0]),
        .data    (wr_data),
        .cls     (cls)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .engine_busy      (engine_busy),
        .cls              (cls),
        .prog_start       (prog_start),
        .sect_erase_start (sect_erase_start),
        .bank_erase_start (bank_erase_start),
        .op_addr          (op_addr),
        .op_data          (op_data),
        .id_set           (id_set),
        .id_clr           (id_clr)
    );

    flash_id_mode #(.ADDR_W(ADDR_W), .DEVICE_CODE(DEVICE_CODE)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_set  (id_set),
        .id_clr  (id_clr),
        .rd_addr (rd_addr),
        .id_mode (id_mode),
        .id_data (id_data)
    );

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int AW = 19;
    localparam logic [7:0] DEV = 8'h17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          engine_busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_start, sect_erase_start, bank_erase_start;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic          id_mode;
    logic [7:0]    id_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DEVICE_CODE(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .engine_busy(engine_busy), .rd_addr(rd_addr),
        .prog_start(prog_start), .sect_erase_start(sect_erase_start),
        .bank_erase_start(bank_erase_start), .op_addr(op_addr),
        .op_data(op_data), .id_mode(id_mode), .id_data(id_data)
    );

    // ---------------- reference model: history of accepted writes ----------
    logic [AW-1:0] hist_a[$];
    logic [7:0]    hist_d[$];
    bit            m_id;
    bit            e_prog, e_se, e_be;
    logic [AW-1:0] e_addr;
    logic [7:0]    e_data;

    // kinds: 0 program, 1 sector erase, 2 bank erase, 3 id entry, 4 id exit
    function automatic int seq_len(int k);
        if (k == 0) return 4;
        if (k <= 2) return 6;
        return 3;
    endfunction

    function automatic bit step_ok(int k, int i, logic [AW-1:0] a, logic [7:0] d);
        logic [14:0] lo;
        lo = a[14:0];
        if (i == 0) return (lo == 15'h5555) && (d == 8'hAA);
        if (i == 1) return (lo == 15'h2AAA) && (d == 8'h55);
        if (i == 2) begin
            if (k == 0) return (lo == 15'h5555) && (d == 8'hA0);
            if (k == 3) return (lo == 15'h5555) && (d == 8'h90);
            if (k == 4) return (lo == 15'h5555) && (d == 8'hF0);
            return (lo == 15'h5555) && (d == 8'h80);
        end
        if (i == 3) begin
            if (k == 0) return 1'b1;
            return (lo == 15'h5555) && (d == 8'hAA);
        end
        if (i == 4) return (lo == 15'h2AAA) && (d == 8'h55);
        if (k == 1) return d == 8'h30;
        return (lo == 15'h5555) && (d == 8'h10);
    endfunction

    task automatic model_reset();
        hist_a.delete(); hist_d.delete();
        m_id = 0; e_prog = 0; e_se = 0; e_be = 0;
    endtask

    task automatic model_step(bit v, logic [AW-1:0] a, logic [7:0] d, bit b);
        int n;
        int full;
        bit pre;
        e_prog = 0; e_se = 0; e_be = 0;
        if (!v || b) return;
        hist_a.push_back(a); hist_d.push_back(d);
        n = hist_a.size();
        full = -1; pre = 0;
        for (int k = 0; k < 5; k++) begin
            bit ok;
            ok = (n <= seq_len(k));
            for (int i = 0; i < n && ok; i++)
                ok = step_ok(k, i, hist_a[i], hist_d[i]);
            if (ok) begin
                if (n == seq_len(k)) full = k;
                else pre = 1;
            end
        end
        if (full >= 0) begin
            if (full == 0) e_prog = 1;
            if (full == 1) e_se = 1;
            if (full == 2) e_be = 1;
            if (full <= 2) begin e_addr = a; e_data = d; end
            if (full == 3) m_id = 1;
            if (full == 4) m_id = 0;
            hist_a.delete(); hist_d.delete();
        end else if (!pre) begin
            m_id = 0;
            hist_a.delete(); hist_d.delete();
        end
    endtask

    // ---------------- checking ------------------------------------------
    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [7:0] eid;
        eid = 8'h00;
        if (m_id && rd_addr == 0) eid = 8'hBF;
        else if (m_id && rd_addr == 1) eid = DEV;
        chk(tag, "prog_start", 32'(prog_start), 32'(e_prog));
        chk(tag, "sect_erase_start", 32'(sect_erase_start), 32'(e_se));
        chk(tag, "bank_erase_start", 32'(bank_erase_start), 32'(e_be));
        chk(tag, "id_mode", 32'(id_mode), 32'(m_id));
        chk(tag, "id_data", 32'(id_data), 32'(eid));
        if (e_prog || e_se || e_be) begin
            chk(tag, "op_addr", 32'(op_addr), 32'(e_addr));
            chk(tag, "op_data", 32'(op_data), 32'(e_data));
        end
    endtask

    task automatic cyc(bit v, logic [AW-1:0] a, logic [7:0] d, bit b, string tag);
        wr_valid = v; wr_addr = a; wr_data = d; engine_busy = b;
        @(posedge clk);
        model_step(v, a, d, b);
        #2;
        compare(tag);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d, string tag);
        cyc(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic gap(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 8'h00, 1'b0, tag);
    endtask

    task automatic unlock(string tag);
        wr(19'h05555, 8'hAA, tag);
        wr(19'h02AAA, 8'h55, tag);
    endtask

    task automatic do_reset();
        wr_valid = 0; engine_busy = 0; rst_n = 0;
        repeat (2) @(posedge clk);
        model_reset();
        #2;
        rst_n = 1;
        compare("R11");
    endtask

    // ---------------- stimulus ------------------------------------------
    initial begin
        model_reset();
        e_addr = '0; e_data = '0;
        do_reset();
        gap(2, "R11");

        // R1: byte program
        unlock("R1"); wr(19'h05555, 8'hA0, "R1"); wr(19'h4_1234, 8'h5A, "R1");
        gap(2, "R1");

        // R2: sector erase, sector address with high bits set
        unlock("R2"); wr(19'h05555, 8'h80, "R2"); unlock("R2");
        wr(19'h7_3ABC, 8'h30, "R2"); gap(1, "R2");

        // R3: bank erase
        unlock("R3"); wr(19'h05555, 8'h80, "R3"); unlock("R3");
        wr(19'h05555, 8'h10, "R3"); gap(1, "R3");

        // R4 / R6: identifier entry and reads
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        rd_addr = 0; gap(1, "R6");
        rd_addr = 1; gap(1, "R6");
        rd_addr = 2; gap(1, "R6");
        rd_addr = 19'h40000; gap(1, "R6");
        rd_addr = 0;

        // R8: a first-step write keeps id mode; R5: three-write exit
        wr(19'h05555, 8'hAA, "R8");
        wr(19'h02AAA, 8'h55, "R5"); wr(19'h05555, 8'hF0, "R5"); gap(1, "R5");
        // R5: lone F0 at any address exits
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        wr(19'h1_0777, 8'hF0, "R5"); gap(1, "R5");

        // R7: high address bits ignored during command steps
        wr(19'h7_5555, 8'hAA, "R7"); wr(19'h2_2AAA, 8'h55, "R7");
        wr(19'h5_5555, 8'hA0, "R7"); wr(19'h0_0042, 8'hC3, "R7");
        wr(19'h6_5555, 8'hAA, "R7"); wr(19'h0_5554, 8'h55, "R7");

        // R8: aborts at each step, with id mode on
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        unlock("R8"); wr(19'h05555, 8'h77, "R8");
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        wr(19'h05555, 8'hAA, "R8"); wr(19'h05555, 8'hAA, "R8");
        unlock("R8"); wr(19'h05555, 8'h80, "R8"); wr(19'h02AAA, 8'hAA, "R8");
        unlock("R8"); wr(19'h05555, 8'h80, "R8"); unlock("R8");
        wr(19'h01234, 8'h10, "R8");
        // R2: 30h at 5555h is a sector erase
        unlock("R2"); wr(19'h05555, 8'h80, "R2"); unlock("R2");
        wr(19'h05555, 8'h30, "R2");

        // R9: busy blocks the final step and the id commands
        unlock("R9"); wr(19'h05555, 8'hA0, "R9");
        cyc(1'b1, 19'h00100, 8'h11, 1'b1, "R9");
        cyc(1'b1, 19'h00101, 8'hF0, 1'b1, "R9");
        wr(19'h00102, 8'h22, "R9");
        unlock("R9"); wr(19'h05555, 8'h80, "R9"); unlock("R9");
        cyc(1'b1, 19'h05555, 8'h10, 1'b1, "R9");
        wr(19'h05555, 8'h10, "R9");
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        cyc(1'b1, 19'h00000, 8'hF0, 1'b1, "R9");
        cyc(1'b1, 19'h00033, 8'h99, 1'b1, "R9");
        gap(1, "R9");

        // R10: back-to-back launches
        unlock("R10"); wr(19'h05555, 8'hA0, "R10"); wr(19'h00010, 8'h01, "R10");
        unlock("R10"); wr(19'h05555, 8'hA0, "R10"); wr(19'h00011, 8'h02, "R10");
        wr(19'h05555, 8'hAA, "R10");

        // R11: reset discards a partial sequence and id mode
        unlock("R4"); wr(19'h05555, 8'h90, "R4");
        unlock("R11"); wr(19'h05555, 8'hA0, "R11");
        do_reset();
        wr(19'h00200, 8'h33, "R11"); gap(1, "R11");

        // R8: biased random stream over all features
        for (int t = 0; t < 4000; t++) begin
            logic [AW-1:0] a;
            logic [7:0]    d;
            int            s;
            s = int'($urandom % 4);
            a = AW'($urandom);
            if (s == 0) a[14:0] = 15'h5555;
            else if (s == 1) a[14:0] = 15'h2AAA;
            else if (s == 2) a[14:0] = 15'h5555;
            s = int'($urandom % 10);
            case (s)
                0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80;
                4: d = 8'h90; 5: d = 8'hF0; 6: d = 8'h30; 7: d = 8'h10;
                8: d = 8'hAA;
                default: d = 8'($urandom);
            endcase
            rd_addr = AW'($urandom % 3);
            cyc(($urandom % 4) != 0, a, d, ($urandom % 8) == 0, "R8");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule